// File: doc/BRIEF.md
# Set-Associative Data Address Translator

This block turns data virtual addresses into physical addresses through a small set-associative translation buffer that software fills. Each slot holds two words. The match word carries a virtual page tag, a valid bit and a small age counter. The translate word carries a physical page number, a cache-inhibit bit and four permission bits. The four bits split read and write permission between user and supervisor mode.

A lookup request carries a virtual address, a write flag, a supervisor flag and a peek flag. A normal lookup returns one of three results:
- a translated address, with the cache-inhibit flag;
- a page fault, when the permission check fails;
- a miss, when no slot matches.

A hit also ages the counters of its set. A peek does the same search and the same permission check, but it changes no counter and reports no fault or miss. With translation switched off, addresses pass through unchanged. In that mode the upper half of the address space is treated as uncached.

Software uses a side port to write and read any word of any slot. Refill after a miss is left to software. Hits and misses take separately configurable numbers of cycles.

Top module: `dtlb_xlate`

## Requirements
- R1: When `mmu_en` or `mmu_present` is low, `rsp_paddr` equals the request address and `rsp_ci` equals its most significant bit. `rsp_hit`, `rsp_fault` and `rsp_miss` stay low in this mode.
- R2: The set index is vaddr[PAGE_BITS +: SET_BITS]. A way matches when bit 0 (valid) of its match word is set and match word bits [ADDR_W-1:PAGE_BITS+SET_BITS] equal the same bits of the address.
- R3: On a hit, `rsp_paddr` is translate-word bits [ADDR_W-1:PAGE_BITS] followed by the address's low PAGE_BITS bits, and `rsp_ci` is translate-word bit 1.
- R4: The age field of a match word is bits [6 +: SET_BITS]. A normal translated hit reloads the hit way's field with all ones. In the same set, every other way with a nonzero field decrements it by one, and a zero field stays zero.
- R5: The translate word holds four permission bits: bit 6 allows user read, bit 7 user write, bit 8 supervisor read and bit 9 supervisor write. A normal hit whose bit for the request's mode and direction is clear reports `rsp_fault` together with `rsp_hit`, and `rsp_vaddr` carries the faulting address.
- R6: A normal lookup with no matching way reports `rsp_miss`, with `rsp_paddr` zero, `rsp_ci` low and `rsp_vaddr` carrying the address.
- R7: A peek never raises `rsp_fault` or `rsp_miss` and leaves every age field unchanged. It returns the translation with `rsp_hit` high only when an entry matches and the permission check passes. Otherwise `rsp_paddr` is zero and `rsp_hit` is low.
- R8: `rsp_valid` pulses for one cycle HIT_LAT cycles after an accepted request for a hit, a bypass or any peek, and MISS_LAT cycles after an accepted request for a normal miss.
- R9: When several ways of the indexed set match, the lowest-numbered way supplies the result.
- R10: With `cfg_we` high, `cfg_wdata` is written to the word chosen by way, set and `cfg_sel` (0 selects the match word, 1 the translate word). `cfg_rdata` shows the word addressed by the read inputs in the same encoding.
- R11: After reset every word reads zero, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mmu_en | input | 1 | Translation enabled |
| mmu_present | input | 1 | Translation unit configured as present |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Request can be accepted |
| req_vaddr | input | ADDR_W | Virtual address |
| req_write | input | 1 | Access is a store |
| req_super | input | 1 | Access is in supervisor mode |
| req_peek | input | 1 | Lookup has no side effects |
| rsp_valid | output | 1 | Result strobe |
| rsp_hit | output | 1 | Matching entry found (for a peek, also permitted) |
| rsp_fault | output | 1 | Data page fault |
| rsp_miss | output | 1 | Translation miss |
| rsp_ci | output | 1 | Cache inhibit |
| rsp_paddr | output | ADDR_W | Physical address |
| rsp_vaddr | output | ADDR_W | Address of the answered request |
| cfg_we | input | 1 | Entry write strobe |
| cfg_way | input | max(WAY_BITS,1) | Write way |
| cfg_set | input | SET_BITS | Write set |
| cfg_sel | input | 1 | Write word select |
| cfg_wdata | input | ADDR_W | Write data |
| cfg_rway | input | max(WAY_BITS,1) | Read way |
| cfg_rset | input | SET_BITS | Read set |
| cfg_rsel | input | 1 | Read word select |
| cfg_rdata | output | ADDR_W | Read data |

## Verification
The bench builds the block with two ways, four sets and 8 KB pages. It uses a hit latency of 1 and a miss latency of 3. Two ways make it possible to test way priority and ageing across neighbours, including the rule that a zero counter stays at zero. The short set count lets the two-bit age field reach its reload value and count down within a few hits. Unequal latencies make any mix-up between the hit and miss timing paths visible at the strobe.

// File: rtl/dtlb_xlate.sv
module dtlb_xlate #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter int SET_BITS  = 6,
  parameter int WAY_BITS  = 0,
  parameter int HIT_LAT   = 1,
  parameter int MISS_LAT  = 4
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    mmu_en,
  input  logic                                    mmu_present,
  input  logic                                    req_valid,
  output logic                                    req_ready,
  input  logic [ADDR_W-1:0]                       req_vaddr,
  input  logic                                    req_write,
  input  logic                                    req_super,
  input  logic                                    req_peek,
  output logic                                    rsp_valid,
  output logic                                    rsp_hit,
  output logic                                    rsp_fault,
  output logic                                    rsp_miss,
  output logic                                    rsp_ci,
  output logic [ADDR_W-1:0]                       rsp_paddr,
  output logic [ADDR_W-1:0]                       rsp_vaddr,
  input  logic                                    cfg_we,
  input  logic [(WAY_BITS > 0 ? WAY_BITS : 1)-1:0] cfg_way,
  input  logic [SET_BITS-1:0]                     cfg_set,
  input  logic                                    cfg_sel,
  input  logic [ADDR_W-1:0]                       cfg_wdata,
  input  logic [(WAY_BITS > 0 ? WAY_BITS : 1)-1:0] cfg_rway,
  input  logic [SET_BITS-1:0]                     cfg_rset,
  input  logic                                    cfg_rsel,
  output logic [ADDR_W-1:0]                       cfg_rdata
);

  localparam int NWAYS   = 1 << WAY_BITS;
  localparam int NSETS   = 1 << SET_BITS;
  localparam int WI      = (WAY_BITS > 0) ? WAY_BITS : 1;
  localparam int TAG_LO  = PAGE_BITS + SET_BITS;
  localparam int AGE_LO  = 6;
  localparam int LAT_MAX = (HIT_LAT > MISS_LAT) ? HIT_LAT : MISS_LAT;
  localparam int CW      = $clog2(LAT_MAX + 1);

  logic [ADDR_W-1:0] mword [NWAYS][NSETS];
  logic [ADDR_W-1:0] tword [NWAYS][NSETS];

  logic [SET_BITS-1:0] set_ix;
  logic                bypass, found, perm_ok, accept, upd;
  logic [WI-1:0]       hway;
  logic [ADDR_W-1:0]   xl_addr;
  logic [CW-1:0]       cnt;
  logic                hit_q, fault_q, miss_q;

  assign set_ix = req_vaddr[PAGE_BITS +: SET_BITS];
  assign bypass = !(mmu_en && mmu_present);

  always_comb begin
    found = 1'b0;
    hway  = '0;
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (mword[w][set_ix][0] &&
          mword[w][set_ix][ADDR_W-1:TAG_LO] == req_vaddr[ADDR_W-1:TAG_LO]) begin
        found = 1'b1;
        hway  = WI'(w);
      end
    end
  end

  assign perm_ok = req_super ? (req_write ? tword[hway][set_ix][9] : tword[hway][set_ix][8])
                             : (req_write ? tword[hway][set_ix][7] : tword[hway][set_ix][6]);
  assign xl_addr = {tword[hway][set_ix][ADDR_W-1:PAGE_BITS], req_vaddr[PAGE_BITS-1:0]};

  assign req_ready = (cnt <= CW'(1));
  assign rsp_valid = (cnt == CW'(1));
  assign accept    = req_valid && req_ready;
  assign upd       = accept && !bypass && !req_peek && found;

  assign rsp_hit   = rsp_valid && hit_q;
  assign rsp_fault = rsp_valid && fault_q;
  assign rsp_miss  = rsp_valid && miss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      hit_q     <= 1'b0;
      fault_q   <= 1'b0;
      miss_q    <= 1'b0;
      rsp_ci    <= 1'b0;
      rsp_paddr <= '0;
      rsp_vaddr <= '0;
    end else if (accept) begin
      rsp_vaddr <= req_vaddr;
      fault_q   <= 1'b0;
      miss_q    <= 1'b0;
      cnt       <= CW'(HIT_LAT);
      if (bypass) begin
        hit_q     <= 1'b0;
        rsp_paddr <= req_vaddr;
        rsp_ci    <= req_vaddr[ADDR_W-1];
      end else if (req_peek) begin
        hit_q     <= found && perm_ok;
        rsp_paddr <= (found && perm_ok) ? xl_addr : '0;
        rsp_ci    <= found && perm_ok && tword[hway][set_ix][1];
      end else if (found) begin
        hit_q     <= 1'b1;
        fault_q   <= !perm_ok;
        rsp_paddr <= xl_addr;
        rsp_ci    <= tword[hway][set_ix][1];
      end else begin
        hit_q     <= 1'b0;
        miss_q    <= 1'b1;
        rsp_paddr <= '0;
        rsp_ci    <= 1'b0;
        cnt       <= CW'(MISS_LAT);
      end
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NWAYS; w++)
        for (int s = 0; s < NSETS; s++) begin
          mword[w][s] <= '0;
          tword[w][s] <= '0;
        end
    end else begin
      if (upd) begin
        for (int w = 0; w < NWAYS; w++) begin
          if (WI'(w) == hway)
            mword[w][set_ix][AGE_LO +: SET_BITS] <= '1;
          else if (mword[w][set_ix][AGE_LO +: SET_BITS] != '0)
            mword[w][set_ix][AGE_LO +: SET_BITS] <= mword[w][set_ix][AGE_LO +: SET_BITS] - 1'b1;
        end
      end
      if (cfg_we) begin
        if (cfg_sel) tword[cfg_way][cfg_set] <= cfg_wdata;
        else         mword[cfg_way][cfg_set] <= cfg_wdata;
      end
    end
  end

  assign cfg_rdata = cfg_rsel ? tword[cfg_rway][cfg_rset] : mword[cfg_rway][cfg_rset];

  AST_FAULT_NOT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_fault && rsp_miss)); // R6
  AST_MISS_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_paddr == '0) && !rsp_ci); // R6
  AST_HIT_KEEPS_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_paddr[PAGE_BITS-1:0] == rsp_vaddr[PAGE_BITS-1:0]); // R3
  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_hit); // R5
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !accept) |=> !rsp_valid); // R8

endmodule

// File: tb/dtlb_xlate_tb.sv
module dtlb_xlate_tb;
  localparam int AW = 32;
  logic clk = 0, rst_n = 0;
  logic mmu_en = 1, mmu_present = 1;
  logic req_valid = 0, req_write = 0, req_super = 0, req_peek = 0;
  logic [AW-1:0] req_vaddr = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_fault, rsp_miss, rsp_ci;
  logic [AW-1:0] rsp_paddr, rsp_vaddr;
  logic cfg_we = 0, cfg_sel = 0, cfg_rsel = 0;
  logic [0:0] cfg_way = '0, cfg_rway = '0;
  logic [1:0] cfg_set = '0, cfg_rset = '0;
  logic [AW-1:0] cfg_wdata = '0, cfg_rdata;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  dtlb_xlate #(.ADDR_W(AW), .PAGE_BITS(13), .SET_BITS(2), .WAY_BITS(1),
               .HIT_LAT(1), .MISS_LAT(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .mmu_en(mmu_en), .mmu_present(mmu_present),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_super(req_super), .req_peek(req_peek),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_miss(rsp_miss), .rsp_ci(rsp_ci), .rsp_paddr(rsp_paddr), .rsp_vaddr(rsp_vaddr),
    .cfg_we(cfg_we), .cfg_way(cfg_way), .cfg_set(cfg_set), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rway(cfg_rway), .cfg_rset(cfg_rset),
    .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata));

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 100000", cyc);
      report();
    end
  end

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk_va(int tag, int set, int off);
    return (AW'(tag) << 15) | (AW'(set) << 13) | AW'(off);
  endfunction
  function automatic logic [AW-1:0] mk_m(int tag, int age, bit v);
    return (AW'(tag) << 15) | (AW'(age) << 6) | AW'(v);
  endfunction
  function automatic logic [AW-1:0] mk_t(logic [AW-1:0] pa, bit ci, logic [3:0] perm);
    return (pa & ~AW'(32'h1FFF)) | (AW'(ci) << 1) | (AW'(perm) << 6);
  endfunction

  task automatic wr(int way, int set, bit sel, logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_way = 1'(way); cfg_set = 2'(set); cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(int way, int set, bit sel, output logic [AW-1:0] d);
    cfg_rway = 1'(way); cfg_rset = 2'(set); cfg_rsel = sel;
    #1 d = cfg_rdata;
  endtask

  task automatic look(logic [AW-1:0] va, bit w, bit sup, bit pk, output int lat);
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_write = w; req_super = sup; req_peek = pk;
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    while (!rsp_valid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset();
    logic [AW-1:0] d;
    check("R11 valid", AW'(rsp_valid), 0);
    check("R11 ready", AW'(req_ready), 1);
    rd(1, 3, 1, d); check("R11 word zero", d, 0);
    rd(0, 2, 0, d); check("R11 match zero", d, 0);
  endtask

  task automatic t_bypass();
    int lat;
    mmu_en = 0;
    look(32'h8000_1234, 0, 0, 0, lat);
    check("R1 addr", rsp_paddr, 32'h8000_1234);
    check("R1 ci high", AW'(rsp_ci), 1);
    check("R1 no flags", AW'({rsp_hit, rsp_fault, rsp_miss}), 0);
    check("R8 bypass latency", AW'(lat), 1);
    look(32'h7FFF_FFFF, 1, 0, 0, lat);
    check("R1 ci low", AW'(rsp_ci), 0);
    mmu_en = 1; mmu_present = 0;
    look(32'hC000_0010, 0, 1, 0, lat);
    check("R1 absent addr", rsp_paddr, 32'hC000_0010);
    check("R1 absent no miss", AW'(rsp_miss), 0);
    mmu_present = 1;
  endtask

  task automatic t_hit_miss();
    int lat;
    wr(0, 1, 0, mk_m(8, 0, 1));
    wr(0, 1, 1, mk_t(32'h1234_6000, 1, 4'hF));
    look(mk_va(8, 1, 'h0abc), 0, 0, 0, lat);
    check("R3 paddr", rsp_paddr, 32'h1234_6abc);
    check("R3 ci", AW'(rsp_ci), 1);
    check("R2 hit", AW'(rsp_hit), 1);
    check("R8 hit latency", AW'(lat), 1);
    look(mk_va(9, 1, 'h10), 0, 0, 0, lat);
    check("R2 tag mismatch miss", AW'(rsp_miss), 1);
    check("R6 paddr zero", rsp_paddr, 0);
    check("R6 vaddr", rsp_vaddr, mk_va(9, 1, 'h10));
    check("R8 miss latency", AW'(lat), 3);
    look(mk_va(8, 2, 'h10), 0, 0, 0, lat);
    check("R2 other set miss", AW'(rsp_miss), 1);
    wr(0, 1, 0, mk_m(8, 0, 0));
    look(mk_va(8, 1, 'h0abc), 0, 0, 0, lat);
    check("R2 invalid miss", AW'(rsp_miss), 1);
  endtask

  task automatic t_perm();
    int lat;
    wr(1, 0, 0, mk_m(5, 0, 1));
    wr(1, 0, 1, mk_t(32'h0004_0000, 0, 4'b0001));
    look(mk_va(5, 0, 4), 0, 0, 0, lat);
    check("R5 user read ok", AW'(rsp_fault), 0);
    look(mk_va(5, 0, 4), 1, 0, 0, lat);
    check("R5 user write fault", AW'(rsp_fault), 1);
    check("R5 fault vaddr", rsp_vaddr, mk_va(5, 0, 4));
    look(mk_va(5, 0, 4), 0, 1, 0, lat);
    check("R5 super read fault", AW'(rsp_fault), 1);
    wr(1, 0, 1, mk_t(32'h0004_0000, 0, 4'b1000));
    look(mk_va(5, 0, 4), 1, 1, 0, lat);
    check("R5 super write ok", AW'({rsp_hit, rsp_fault}), 2);
    look(mk_va(5, 0, 4), 1, 0, 0, lat);
    check("R5 user write fault2", AW'(rsp_fault), 1);
  endtask

  task automatic t_age();
    int lat;
    logic [AW-1:0] d;
    wr(0, 2, 0, mk_m(3, 2, 1)); wr(0, 2, 1, mk_t(32'h0010_0000, 0, 4'hF));
    wr(1, 2, 0, mk_m(4, 1, 1)); wr(1, 2, 1, mk_t(32'h0020_0000, 0, 4'hF));
    look(mk_va(4, 2, 0), 0, 0, 0, lat);
    rd(1, 2, 0, d); check("R4 hit reload", d, mk_m(4, 3, 1));
    rd(0, 2, 0, d); check("R4 other decrement", d, mk_m(3, 1, 1));
    look(mk_va(3, 2, 0), 0, 0, 0, lat);
    rd(0, 2, 0, d); check("R4 reload way0", d, mk_m(3, 3, 1));
    rd(1, 2, 0, d); check("R4 decrement way1", d, mk_m(4, 2, 1));
    wr(0, 2, 0, mk_m(3, 0, 1));
    look(mk_va(4, 2, 0), 0, 0, 0, lat);
    rd(0, 2, 0, d); check("R4 zero stays", d, mk_m(3, 0, 1));
    look(mk_va(4, 2, 0), 0, 0, 1, lat);
    check("R7 peek hit", rsp_paddr, 32'h0020_0000);
    check("R7 peek hit flag", AW'(rsp_hit), 1);
    rd(1, 2, 0, d); check("R7 peek no age way1", d, mk_m(4, 3, 1));
    rd(0, 2, 0, d); check("R7 peek no age way0", d, mk_m(3, 0, 1));
  endtask

  task automatic t_peek_fail();
    int lat;
    look(mk_va(5, 0, 4), 0, 0, 1, lat);
    check("R7 peek perm zero", rsp_paddr, 0);
    check("R7 peek no fault", AW'({rsp_hit, rsp_fault, rsp_miss}), 0);
    look(mk_va(30, 3, 4), 0, 0, 1, lat);
    check("R7 peek miss zero", rsp_paddr, 0);
    check("R7 peek no miss", AW'({rsp_hit, rsp_fault, rsp_miss}), 0);
    check("R8 peek latency", AW'(lat), 1);
  endtask

  task automatic t_prio();
    int lat;
    wr(0, 3, 0, mk_m(7, 0, 1)); wr(0, 3, 1, mk_t(32'hAAAA_0000, 0, 4'hF));
    wr(1, 3, 0, mk_m(7, 0, 1)); wr(1, 3, 1, mk_t(32'h5555_4000, 1, 4'hF));
    look(mk_va(7, 3, 'h44), 0, 0, 0, lat);
    check("R9 way0 wins", rsp_paddr, 32'hAAAA_0044);
    check("R9 way0 ci", AW'(rsp_ci), 0);
    wr(0, 3, 0, mk_m(7, 0, 0));
    look(mk_va(7, 3, 'h44), 0, 0, 0, lat);
    check("R10 way1 after rewrite", rsp_paddr, 32'h5555_4044);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_bypass();
    t_hit_miss();
    t_perm();
    t_age();
    t_peek_fail();
    t_prio();
    repeat (4) @(negedge clk);
    report();
  end
endmodule